// File: doc/BRIEF.md
# Sequential Histogram Median Unit

This block returns the median of a window of nine 8-bit samples. It does not sort the samples. Instead it builds a count of how many samples have each possible value, and then walks those counts from the lowest value upward. The counts live in a small synchronous RAM with 256 entries, one for each sample value. A single adder serves every addition, and the work is spread over a few hundred clock cycles. This keeps the datapath small at the cost of latency.

A caller presents all nine samples packed on one bus and pulses `start_i` while the unit is idle. The unit then works through four phases in order:

- It zeroes every count.
- It adds one to the count for each sample, reading and then writing back each entry.
- It adds the counts from value 0 upward and stops at the first value where the running total passes four.
- It reports that value on `median_o` with a one-cycle `done_o`.

Top module: `median_hist`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `median_o` are all zero.
- R2: A `start_i` high at a clock edge while idle captures `samples_i`, with sample k in bits [8k+7:8k]. `busy_o` is high from the next cycle.
- R3: `median_o` reports the lowest value v for which more than four of the nine samples are less than or equal to v.
- R4: Repeated sample values are all counted, including equal samples held in adjacent sample slots.
- R5: Every count is cleared at the start of each window, so a result does not depend on earlier windows.
- R6: `start_i` has no effect while `busy_o` is high. The captured samples, the result and the number of `done_o` pulses stay as they were.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is low in the cycle after it.
- R8: `median_o` changes only together with a `done_o` pulse, and holds its value between pulses.
- R9: Extreme values work: all 0 gives 0, all 255 gives 255, and five or more samples of 255 give 255.
- R10: No stored count and no running total ever exceeds nine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a window; taken only while idle |
| samples_i | input | 72 | Nine samples; sample k in bits [8k+7:8k] |
| busy_o | output | 1 | High while a window is being processed |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| median_o | output | 8 | Median of the last window that finished |

## Verification
A bin left uncleared, or a read-modify-write that loses a count, shows up at the ports as a wrong `median_o`. It appears at the `done_o` of the window affected, which comes a few hundred cycles after the start pulse. The bench therefore runs windows back to back without a reset between them, so that stale counts carry over and bias the next result. It also includes patterns whose median falls exactly on a count boundary. A phase sequence that goes wrong instead shows up as a missing, doubled or early `done_o`, or as `busy_o` failing to rise one cycle after the start pulse.

// File: rtl/median_pkg.sv
package median_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FILL_RD,
    ST_FILL_WR,
    ST_SCAN,
    ST_DONE
  } med_state_e;
endpackage

// File: rtl/median_bin_ram.sv
module median_bin_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/median_ctrl.sv
module median_ctrl
  import median_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int N_SAMPLES = 9,
  localparam int CNT_W = $clog2(N_SAMPLES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [N_SAMPLES*SAMPLE_W-1:0] samples_i,
  output logic                          ram_we_o,
  output logic [SAMPLE_W-1:0]           ram_addr_o,
  output logic [CNT_W-1:0]              ram_wdata_o,
  input  logic [CNT_W-1:0]              ram_rdata_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [SAMPLE_W-1:0]           median_o
);
  localparam int BINS  = 1 << SAMPLE_W;
  localparam int RANK  = N_SAMPLES / 2;
  localparam int IDX_W = (N_SAMPLES > 1) ? $clog2(N_SAMPLES) : 1;

  med_state_e                    state_q;
  logic [SAMPLE_W-1:0]           addr_q, rd_idx_q, median_q;
  logic [IDX_W-1:0]              idx_q;
  logic [N_SAMPLES*SAMPLE_W-1:0] samples_q;
  logic [CNT_W-1:0]              sum_q;
  logic                          rd_vld_q;

  logic [SAMPLE_W-1:0] cur_sample;
  logic [CNT_W-1:0]    add_a, add_b, add_y;

  assign cur_sample = samples_q[int'(idx_q)*SAMPLE_W +: SAMPLE_W];

  // single shared adder: bin increment in FILL, running sum in SCAN
  always_comb begin
    add_a = '0;
    add_b = '0;
    if (state_q == ST_FILL_WR) begin
      add_a = ram_rdata_i;
      add_b = CNT_W'(1);
    end else if (state_q == ST_SCAN) begin
      add_a = sum_q;
      add_b = ram_rdata_i;
    end
  end
  assign add_y = add_a + add_b;

  always_comb begin
    ram_we_o    = 1'b0;
    ram_addr_o  = addr_q;
    ram_wdata_o = '0;
    case (state_q)
      ST_CLEAR:   ram_we_o = 1'b1;
      ST_FILL_RD: ram_addr_o = cur_sample;
      ST_FILL_WR: begin
        ram_we_o    = 1'b1;
        ram_addr_o  = cur_sample;
        ram_wdata_o = add_y;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      rd_idx_q  <= '0;
      median_q  <= '0;
      idx_q     <= '0;
      samples_q <= '0;
      sum_q     <= '0;
      rd_vld_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          samples_q <= samples_i;
          addr_q    <= '0;
          state_q   <= ST_CLEAR;
        end
        ST_CLEAR: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == SAMPLE_W'(BINS - 1)) begin
            idx_q   <= '0;
            state_q <= ST_FILL_RD;
          end
        end
        ST_FILL_RD: state_q <= ST_FILL_WR;
        ST_FILL_WR: begin
          // write lands before the next read is issued, so equal samples chain
          if (idx_q == IDX_W'(N_SAMPLES - 1)) begin
            addr_q   <= '0;
            sum_q    <= '0;
            rd_vld_q <= 1'b0;
            state_q  <= ST_SCAN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_FILL_RD;
          end
        end
        ST_SCAN: begin
          if (addr_q != SAMPLE_W'(BINS - 1)) addr_q <= addr_q + 1'b1;
          rd_vld_q <= 1'b1;
          rd_idx_q <= addr_q;
          if (rd_vld_q) begin
            sum_q <= add_y;
            if (add_y > CNT_W'(RANK)) begin
              median_q <= rd_idx_q;
              state_q  <= ST_DONE;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign median_o = median_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(samples_q));
  assert_median_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SCAN) |=> $stable(median_o));
  assert_sum_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_q <= CNT_W'(N_SAMPLES));
  assert_bin_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_wdata_o <= CNT_W'(N_SAMPLES)));
  assert_busy_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
endmodule

// File: rtl/median_hist.sv
module median_hist #(
  parameter int SAMPLE_W  = 8,
  parameter int N_SAMPLES = 9
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [N_SAMPLES*SAMPLE_W-1:0] samples_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [SAMPLE_W-1:0]           median_o
);
  localparam int CNT_W = $clog2(N_SAMPLES + 1);

  logic                ram_we;
  logic [SAMPLE_W-1:0] ram_addr;
  logic [CNT_W-1:0]    ram_wdata, ram_rdata;

  median_ctrl #(.SAMPLE_W(SAMPLE_W), .N_SAMPLES(N_SAMPLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .samples_i   (samples_i),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .median_o    (median_o)
  );

  median_bin_ram #(.ADDR_W(SAMPLE_W), .DATA_W(CNT_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );
endmodule

// File: tb/tb_median_hist.sv
module tb_median_hist;
  localparam int W = 8;
  localparam int N = 9;
  localparam int NV = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] samples = '0;
  logic           busy, done;
  logic [W-1:0]   median;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  median_hist dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .samples_i(samples),
    .busy_o(busy), .done_o(done), .median_o(median)
  );

  // samples listed slot 8 down to slot 0
  localparam logic [N*W-1:0] VEC_S [NV] = '{
    {8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1},
    {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd4, 8'd3, 8'd2, 8'd1, 8'd7, 8'd7, 8'd7, 8'd7, 8'd7},
    {8'd90, 8'd0, 8'd255, 8'd90, 8'd10, 8'd150, 8'd10, 8'd90, 8'd200},
    {8'd9, 8'd9, 8'd9, 8'd9, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd128, 8'd200, 8'd3, 8'd200, 8'd3, 8'd200, 8'd3, 8'd200, 8'd3}
  };
  localparam logic [W-1:0] VEC_M [NV] = '{
    8'd5, 8'd0, 8'd255, 8'd255, 8'd7, 8'd90, 8'd0, 8'd128
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [N*W-1:0] s);
    @(negedge clk);
    start = 1'b1;
    samples = s;
    @(negedge clk);
    start = 1'b0;
    samples = '0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
  endtask

  task automatic wait_done(output bit seen);
    int cyc = 0;
    seen = 1'b0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    seen = done;
  endtask

  task automatic run_window(input logic [N*W-1:0] s, input logic [W-1:0] exp, input string req);
    bit seen;
    kick(s);
    wait_done(seen);
    chk(seen, "R7 done seen", int'(seen), 1);
    chk(median == exp, req, int'(median), int'(exp));
    @(negedge clk);
    chk(!done && !busy, "R7 single done pulse then idle", int'({done, busy}), 0);
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen;
    int extra;
    logic [W-1:0] held;
    #9;
    // R1 reset state
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done at reset", int'(done), 0);
    chk(median == '0, "R1 median at reset", int'(median), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R9: back-to-back windows, no reset between
    for (int i = 0; i < NV; i++) begin
      run_window(VEC_S[i], VEC_M[i], "R3 R4 R5 R9 median");
    end

    // R6: start during busy is ignored
    kick({8'd9, 8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1});
    repeat (10) @(negedge clk);
    start = 1'b1;
    samples = {N{8'd255}};
    @(negedge clk);
    start = 1'b0;
    samples = '0;
    wait_done(seen);
    chk(seen && median == 8'd5, "R6 ignored start kept window", int'(median), 5);
    held = median;
    extra = 0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) extra++;
      if (median != held) extra += 100;
    end
    chk(extra == 0, "R6 R8 no extra done, median held", extra, 0);
    chk(busy == 1'b0, "R6 idle after ignored start", int'(busy), 0);

    // R5: window after all-255 must not inherit counts
    run_window({N{8'd255}}, 8'd255, "R9 all max");
    run_window({8'd2, 8'd2, 8'd2, 8'd2, 8'd2, 8'd1, 8'd1, 8'd1, 8'd1}, 8'd2, "R5 fresh bins");

    // R8: median holds while idle
    held = median;
    repeat (20) @(negedge clk);
    chk(median == held, "R8 median holds idle", int'(median), int'(held));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule